// File: doc/BRIEF.md
# Interrupt Pending and Masking Unit

This block holds the pending-interrupt vector of a processor's system-control coprocessor. There are eight pending lines. Software or hardware sources use single-cycle strobes to set one line, clear one line, or wipe the whole vector. A line number comes with each set or clear. A number that names no line is refused, and an error flag is raised for one cycle.

A free-running cycle counter is compared with a programmable match value. When the two are equal and the counter is not zero, the pending line chosen by a software-written timer-line selector is set. A counter value of zero never produces a timer event.

The unit also produces a registered request to take an interrupt. The request needs all of the following:
- the global enable is on;
- neither the exception level nor the error level is set;
- at least one pending line is enabled by the 8-bit mask.

A separate flag reports whether any line is pending at all, whatever the mask and the enable bits say.

Top module: `irq_pending_unit`

## Requirements
- R1: A set strobe with line number n in 0..7 sets pending bit n and no other bit.
- R2: A clear strobe with line number n in 0..7 clears pending bit n and no other bit.
- R3: A clear-all strobe makes every pending bit 0 and overrides set and clear strobes in the same cycle.
- R4: A set or clear strobe whose 4-bit line number is 8..15 leaves the pending vector unchanged and drives the error flag high in the next cycle. The flag is low in any cycle after one with no such strobe.
- R5: When set and clear name the same line in the same cycle, the bit ends up 1.
- R6: A timer event occurs when the match value equals the counter and the counter is nonzero. It sets the pending bit whose number is given by the 3-bit timer-line selector. A counter of zero never sets a bit through this path.
- R7: A timer event on a line wins over a clear, or a clear-all, that targets the same line in the same cycle.
- R8: The interrupt request is a register. In the cycle after an edge, it is 1 exactly when, at that edge, enable was 1, exception level was 0, error level was 0, and the mask ANDed with the pending vector was nonzero.
- R9: The any-pending flag equals the OR of all pending bits, independent of the mask and the enable/level inputs.
- R10: While reset is asserted, the pending vector, the error flag and the interrupt request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| exc_lvl | input | 1 | Exception level; blocks requests when 1 |
| err_lvl | input | 1 | Error level; blocks requests when 1 |
| line_mask | input | 8 | Per-line enable mask, aligned with the pending vector |
| tmr_line | input | 3 | Pending line that the timer event sets |
| tick_count | input | 32 | Free-running counter value |
| tick_match | input | 32 | Timer match value |
| set_stb | input | 1 | Set the line named by line_num |
| clr_stb | input | 1 | Clear the line named by line_num |
| clr_all | input | 1 | Clear every pending line |
| line_num | input | 4 | Line number for set and clear strobes |
| pend_vec | output | 8 | Pending vector |
| pend_any | output | 1 | Any line pending |
| take_irq | output | 1 | Registered interrupt request |
| num_err | output | 1 | Out-of-range line number seen in the previous cycle |

## Verification
Directed sequences separate each priority case from the others:
- set against clear on one line;
- clear-all against set;
- a timer hit against a clear;
- a zero counter against a nonzero one.

Sweeping the mask and the enable/level inputs over a fixed pending vector shows that each gating input blocks the request on its own and never affects the any-pending flag. Out-of-range numbers are sent with both strobe types, so a wrong range test or an unblocked write shows up in the pending vector. A long pseudo-random phase mixes all strobes with near-equal counter and match values, and the results are compared cycle by cycle with a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Gating conditions that decide whether a pending line may be taken
  typedef struct packed {
    logic glb_en;
    logic exc_lvl;
    logic err_lvl;
  } irq_gate_t;

  function automatic logic gate_open(irq_gate_t g);
    return g.glb_en & ~g.exc_lvl & ~g.err_lvl;
  endfunction
endpackage

// File: rtl/irq_line_decode.sv
module irq_line_decode #(
  parameter int LINES = 8,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [LINES-1:0] onehot,
  output logic             in_range
);
  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_dec
      assign onehot[gi] = (idx == IDX_W'(gi));
    end
  endgenerate

  assign in_range = |onehot;
endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match #(
  parameter int LINES = 8,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match,
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] tmask
);
  logic hit;
  assign hit = (count == match) && (count != '0);

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_sel
      assign tmask[gi] = hit && (sel == SEL_W'(gi));
    end
  endgenerate
endmodule

// File: rtl/irq_pending_core.sv
module irq_pending_core #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_v,
  input  logic             clr_v,
  input  logic             wipe,
  input  logic             bad_num,
  input  logic [LINES-1:0] num_mask,
  input  logic [LINES-1:0] tmr_mask,
  output logic [LINES-1:0] pend_q,
  output logic             err_q
);
  logic [LINES-1:0] set_mask, clr_mask, pend_d;
  logic             pend_en, err_d;

  always_comb begin
    set_mask = set_v ? num_mask : '0;
    clr_mask = clr_v ? num_mask : '0;
    if (wipe) begin
      pend_d = tmr_mask;
    end else begin
      pend_d = ((pend_q & ~clr_mask) | set_mask) | tmr_mask;
    end
    pend_en = set_v | clr_v | wipe | (|tmr_mask);
    err_d   = bad_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
  parameter int LINES = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             exc_lvl,
  input  logic             err_lvl,
  input  logic [LINES-1:0] line_mask,
  input  logic [SEL_W-1:0] tmr_line,
  input  logic [CNT_W-1:0] tick_count,
  input  logic [CNT_W-1:0] tick_match,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] line_num,
  output logic [LINES-1:0] pend_vec,
  output logic             pend_any,
  output logic             take_irq,
  output logic             num_err
);
  import irq_pkg::*;

  logic [LINES-1:0] num_mask, tmr_mask;
  logic             num_ok, bad_num;
  irq_gate_t        gate;
  logic             irq_d;

  irq_line_decode #(.LINES(LINES), .IDX_W(IDX_W)) u_dec (
    .idx      (line_num),
    .onehot   (num_mask),
    .in_range (num_ok)
  );

  irq_timer_match #(.LINES(LINES), .CNT_W(CNT_W)) u_tmr (
    .count (tick_count),
    .match (tick_match),
    .sel   (tmr_line),
    .tmask (tmr_mask)
  );

  assign bad_num = (set_stb | clr_stb) & ~num_ok;

  irq_pending_core #(.LINES(LINES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (set_stb & num_ok),
    .clr_v    (clr_stb & num_ok),
    .wipe     (clr_all),
    .bad_num  (bad_num),
    .num_mask (num_mask),
    .tmr_mask (tmr_mask),
    .pend_q   (pend_vec),
    .err_q    (num_err)
  );

  always_comb begin
    gate.glb_en  = glb_en;
    gate.exc_lvl = exc_lvl;
    gate.err_lvl = err_lvl;
    irq_d        = gate_open(gate) & (|(line_mask & pend_vec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_irq <= 1'b0;
    end else begin
      take_irq <= irq_d;
    end
  end

  assign pend_any = |pend_vec;
endmodule

// File: rtl/irq_pending_checker.sv
module irq_pending_checker #(
  parameter int LINES = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             exc_lvl,
  input logic             err_lvl,
  input logic [LINES-1:0] line_mask,
  input logic [SEL_W-1:0] tmr_line,
  input logic [CNT_W-1:0] tick_count,
  input logic [CNT_W-1:0] tick_match,
  input logic             set_stb,
  input logic             clr_stb,
  input logic             clr_all,
  input logic [IDX_W-1:0] line_num,
  input logic [LINES-1:0] pend_vec,
  input logic             pend_any,
  input logic             take_irq,
  input logic             num_err
);
  logic hit, ok;
  logic [SEL_W-1:0] nsel;
  assign hit  = (tick_match == tick_count) && (|tick_count);
  assign ok   = (int'(line_num) < LINES);
  assign nsel = line_num[SEL_W-1:0];

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && ok && !clr_all) |=> pend_vec[$past(nsel)]);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb && ok && !clr_all && !(hit && tmr_line == nsel))
      |=> !pend_vec[$past(nsel)]);

  p_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !hit) |=> (pend_vec == '0));

  p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_stb || clr_stb) && !ok && !clr_all && !hit)
      |=> (num_err && pend_vec == $past(pend_vec)));

  p_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_vec[$past(tmr_line)]);

  p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_count == '0 && !set_stb && !clr_stb && !clr_all)
      |=> (pend_vec == $past(pend_vec)));

  p_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ($past(glb_en) && !$past(exc_lvl) && !$past(err_lvl)
                  && $past(pend_any)));

  p_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(pend_vec) != '0);
endmodule

bind irq_pending_unit irq_pending_checker #(
  .LINES(LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/irq_pending_unit_test.sv
module irq_pending_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en, exc_lvl, err_lvl;
  logic [7:0]  line_mask;
  logic [2:0]  tmr_line;
  logic [31:0] tick_count, tick_match;
  logic        set_stb, clr_stb, clr_all;
  logic [3:0]  line_num;
  logic [7:0]  pend_vec;
  logic        pend_any, take_irq, num_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R10";

  // reference state
  logic [7:0] m_pend;
  logic       m_irq, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pending_unit uut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .exc_lvl(exc_lvl),
    .err_lvl(err_lvl), .line_mask(line_mask), .tmr_line(tmr_line),
    .tick_count(tick_count), .tick_match(tick_match), .set_stb(set_stb),
    .clr_stb(clr_stb), .clr_all(clr_all), .line_num(line_num),
    .pend_vec(pend_vec), .pend_any(pend_any), .take_irq(take_irq),
    .num_err(num_err)
  );

  always @(posedge clk) begin
    logic [7:0] nxt;
    int n;
    if (!rst_n) begin
      m_pend = 8'h00; m_irq = 1'b0; m_err = 1'b0;
    end else begin
      n   = int'(line_num);
      nxt = m_pend;
      if (clr_all) nxt = 8'h00;
      else begin
        if (clr_stb && n < 8) nxt[n] = 1'b0;
        if (set_stb && n < 8) nxt[n] = 1'b1;
      end
      if (tick_count == tick_match && tick_count != 0) nxt[tmr_line] = 1'b1;
      m_irq  = glb_en && !exc_lvl && !err_lvl && ((line_mask & m_pend) != 0);
      m_err  = (set_stb || clr_stb) && n >= 8;
      m_pend = nxt;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cur_req, "pend_vec", 32'(pend_vec), 32'(m_pend));
    check("R9", "pend_any", 32'(pend_any), 32'(m_pend != 0));
    check("R8", "take_irq", 32'(take_irq), 32'(m_irq));
    check("R4", "num_err", 32'(num_err), 32'(m_err));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    set_stb = 0; clr_stb = 0; clr_all = 0; line_num = 0;
  endtask

  task automatic strobe(logic s, logic c, logic a, logic [3:0] n);
    set_stb = s; clr_stb = c; clr_all = a; line_num = n;
    cyc();
    idle();
  endtask

  initial begin
    rst_n = 0; glb_en = 0; exc_lvl = 0; err_lvl = 0; line_mask = 8'hFF;
    tmr_line = 3'd7; tick_count = 0; tick_match = 0;
    idle();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cur_req = "R10";
    check("R10", "reset pend_vec", 32'(pend_vec), 0);
    check("R10", "reset take_irq", 32'(take_irq), 0);
    check("R10", "reset num_err", 32'(num_err), 0);
    rst_n = 1;
    cyc();

    cur_req = "R1";
    strobe(1, 0, 0, 4'd3);
    check("R1", "set line 3", 32'(pend_vec), 32'h08);
    strobe(1, 0, 0, 4'd0);
    strobe(1, 0, 0, 4'd7);
    check("R1", "set lines 0,7", 32'(pend_vec), 32'h89);

    cur_req = "R2";
    strobe(0, 1, 0, 4'd3);
    check("R2", "clear line 3", 32'(pend_vec), 32'h81);

    cur_req = "R5";
    strobe(1, 1, 0, 4'd5);
    check("R5", "set beats clear", 32'(pend_vec), 32'hA1);

    cur_req = "R4";
    strobe(1, 0, 0, 4'd9);
    check("R4", "bad set ignored", 32'(pend_vec), 32'hA1);
    check("R4", "bad set flagged", 32'(num_err), 1);
    strobe(0, 1, 0, 4'd13);
    check("R4", "bad clear ignored", 32'(pend_vec), 32'hA1);
    cyc();
    check("R4", "flag drops", 32'(num_err), 0);

    cur_req = "R8";
    line_mask = 8'h20; glb_en = 1; cyc(); cyc();
    check("R8", "request taken", 32'(take_irq), 1);
    exc_lvl = 1; cyc();
    check("R8", "exc level blocks", 32'(take_irq), 0);
    exc_lvl = 0; err_lvl = 1; cyc();
    check("R8", "err level blocks", 32'(take_irq), 0);
    err_lvl = 0; line_mask = 8'h02; cyc();
    check("R8", "masked off", 32'(take_irq), 0);
    check("R9", "any ignores mask", 32'(pend_any), 1);
    glb_en = 0; line_mask = 8'hFF; cyc();
    check("R8", "enable off", 32'(take_irq), 0);

    cur_req = "R3";
    strobe(1, 0, 1, 4'd2);
    check("R3", "wipe beats set", 32'(pend_vec), 0);

    cur_req = "R6";
    tmr_line = 3'd4; tick_count = 0; tick_match = 0; cyc();
    check("R6", "zero count no event", 32'(pend_vec), 0);
    tick_count = 32'd77; tick_match = 32'd77; cyc();
    check("R6", "timer sets line 4", 32'(pend_vec), 32'h10);

    cur_req = "R7";
    strobe(0, 1, 0, 4'd4);
    check("R7", "timer beats clear", 32'(pend_vec), 32'h10);
    strobe(0, 0, 1, 4'd0);
    check("R7", "timer beats wipe", 32'(pend_vec), 32'h10);
    tick_match = 32'd78;
    strobe(0, 1, 0, 4'd4);
    check("R2", "clear after match moves", 32'(pend_vec), 0);

    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      glb_en    = 1'($urandom);
      exc_lvl   = ($urandom % 4) == 0;
      err_lvl   = ($urandom % 5) == 0;
      line_mask = 8'($urandom);
      tmr_line  = 3'($urandom);
      tick_count = $urandom % 3;
      tick_match = $urandom % 3;
      set_stb   = ($urandom % 3) == 0;
      clr_stb   = ($urandom % 3) == 0;
      clr_all   = ($urandom % 12) == 0;
      line_num  = 4'($urandom % 11);
      cyc();
    end
    idle();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule